// File: doc/BRIEF.md
# Memory-Region Hazard Scoreboard for Accelerator Operations

This block keeps a processor and several accelerator units working at the same time on one shared memory. Every accelerator operation reads one block of memory and writes another. Each block is given as a base address and a size that is a power of two. The block is aligned, so the low address bits below its size are ignored. The scoreboard holds the blocks of every operation still in flight in a small table. It checks each processor load or store, and each new accelerator operation, against that table. It stalls any access that would let a later action see or disturb memory out of program order.

A second small table lists the accelerator functions whose configurations are resident. An operation that names a defined function that is not resident raises a load request with that function's identifier. The operation stays stalled until the request is acknowledged. The newly loaded function then replaces the resident slots in round-robin order. An operation is freed from the table by a one-cycle completion pulse from the unit that runs it.

Top module: `region_scoreboard`

## Requirements
- R1: After reset the table is empty and no processor access stalls. The resident functions are 0, 1, 2 and 3, and no load request is raised.
- R2: A processor store (`cpuWrite`=1) stalls while its address falls inside the source or the destination block of any in-flight operation.
- R3: A processor load (`cpuWrite`=0) stalls only when its address falls inside an in-flight destination block. A load inside an in-flight source block proceeds.
- R4: A new operation stalls if its destination block overlaps any in-flight source or destination block.
- R5: A new operation stalls if its source block overlaps an in-flight destination block. Overlap with an in-flight source block alone does not stall it.
- R6: A block spans 2^log bytes, starting at its base with the low log bits cleared. Two blocks overlap when they agree on all address bits above the larger of their two sizes.
- R7: The table holds four in-flight operations. While all four entries are valid, a new operation stalls.
- R8: Each unit runs at most one operation at a time. An operation aimed at a unit with an operation in flight stalls.
- R9: A completion pulse on `donePulse[u]` frees the entry of unit u at the next clock edge. In the cycle of the pulse itself, stall decisions still see the entry.
- R10: An operation whose function is defined but not resident drives `ctxReq`=1 with `ctxFunc` equal to its function and stays stalled. When the request is acknowledged, the function replaces resident slot 0, 1, 2, 3 in turn. From the next cycle it counts as resident.
- R11: `opGrant` is 1 exactly when `opValid` is 1 and `opStall` is 0. A granted operation enters the table at that clock edge.
- R12: Function identifiers 14 and above are undefined. An operation that names one stalls and raises no load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor memory access present |
| cpuWrite | input | 1 | 1 for store, 0 for load |
| cpuAddr | input | ADDR_W | Processor access address |
| cpuStall | output | 1 | Processor access must wait |
| opValid | input | 1 | Accelerator operation offered for issue |
| opFunc | input | FUNC_W | Function identifier of the operation |
| opUnit | input | UNIT_W | Unit that will run the operation |
| opSrcBase | input | ADDR_W | Source block base address |
| opSrcLog | input | LOG_W | Source block size as log2 bytes |
| opDstBase | input | ADDR_W | Destination block base address |
| opDstLog | input | LOG_W | Destination block size as log2 bytes |
| opStall | output | 1 | Offered operation must wait |
| opGrant | output | 1 | Offered operation is issued this cycle |
| donePulse | input | NUM_UNITS | Per-unit completion pulse |
| ctxReq | output | 1 | Request to load a function configuration |
| ctxFunc | output | FUNC_W | Function to load |
| ctxAck | input | 1 | Load request completed |

## Verification
Several events can fall in the same cycle: a completion pulse that frees an entry, and a new operation that would be blocked only by that entry or by a full table. The bench raises the pulse while the blocked operation is held. It expects a stall in that cycle and a grant in the next. A load acknowledge and the held operation also coincide. There the bench expects a stall in the acknowledge cycle and a grant one cycle later. A behavioural model built from region intervals decides every cycle's expected stalls, grants and requests.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic alloc;       // write offered operation into a free entry
    logic ctxInstall;  // replace the round-robin slot with offered function
  } sbStrobes_t;
endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LOG_W       = 4,
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_UNITS   = 8,
  parameter int UNIT_W      = $clog2(NUM_UNITS),
  parameter int FUNC_W      = 4,
  parameter int NUM_FUNCS   = 14,
  parameter int NUM_CTX     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic [FUNC_W-1:0]      opFunc,
  input  logic [UNIT_W-1:0]      opUnit,
  input  logic [ADDR_W-1:0]      opSrcBase,
  input  logic [LOG_W-1:0]       opSrcLog,
  input  logic [ADDR_W-1:0]      opDstBase,
  input  logic [LOG_W-1:0]       opDstLog,
  input  logic [NUM_UNITS-1:0]   donePulse,
  input  sbStrobes_t             strobes,
  output logic                   cpuHitSrc,
  output logic                   cpuHitDst,
  output logic                   opDstHit,
  output logic                   opSrcHit,
  output logic                   tableFull,
  output logic                   unitBusy,
  output logic                   ctxHit,
  output logic                   funcDefined,
  output logic [NUM_ENTRIES-1:0] entryValid
);
  localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  function automatic logic blocksMeet(input logic [ADDR_W-1:0] a, input logic [LOG_W-1:0] la,
                                      input logic [ADDR_W-1:0] b, input logic [LOG_W-1:0] lb);
    logic [LOG_W-1:0]  wider;
    logic [ADDR_W-1:0] keep;
    wider = (la > lb) ? la : lb;
    keep  = {ADDR_W{1'b1}} << wider;
    return ((a ^ b) & keep) == '0;
  endfunction

  // In-flight table
  logic [ADDR_W-1:0] srcBase [NUM_ENTRIES];
  logic [LOG_W-1:0]  srcLog  [NUM_ENTRIES];
  logic [ADDR_W-1:0] dstBase [NUM_ENTRIES];
  logic [LOG_W-1:0]  dstLog  [NUM_ENTRIES];
  logic [UNIT_W-1:0] unitOf  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid;

  logic [NUM_ENTRIES-1:0] cpuSrcVec, cpuDstVec, dstVsAnyVec, srcVsDstVec, busyVec;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gCompare
      assign cpuSrcVec[g]   = valid[g] && blocksMeet(cpuAddr, '0, srcBase[g], srcLog[g]);
      assign cpuDstVec[g]   = valid[g] && blocksMeet(cpuAddr, '0, dstBase[g], dstLog[g]);
      assign dstVsAnyVec[g] = valid[g] &&
                              (blocksMeet(opDstBase, opDstLog, dstBase[g], dstLog[g]) ||
                               blocksMeet(opDstBase, opDstLog, srcBase[g], srcLog[g]));
      assign srcVsDstVec[g] = valid[g] && blocksMeet(opSrcBase, opSrcLog, dstBase[g], dstLog[g]);
      assign busyVec[g]     = valid[g] && (unitOf[g] == opUnit);
    end
  endgenerate

  assign cpuHitSrc  = |cpuSrcVec;
  assign cpuHitDst  = |cpuDstVec;
  assign opDstHit   = |dstVsAnyVec;
  assign opSrcHit   = |srcVsDstVec;
  assign unitBusy   = |busyVec;
  assign tableFull  = &valid;
  assign entryValid = valid;

  logic [ENT_W-1:0] freeIdx;
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) freeIdx = ENT_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        srcBase[i] <= '0;
        srcLog[i]  <= '0;
        dstBase[i] <= '0;
        dstLog[i]  <= '0;
        unitOf[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (valid[i] && donePulse[unitOf[i]]) valid[i] <= 1'b0;
        if (strobes.alloc && freeIdx == ENT_W'(i)) begin
          valid[i]   <= 1'b1;
          srcBase[i] <= opSrcBase;
          srcLog[i]  <= opSrcLog;
          dstBase[i] <= opDstBase;
          dstLog[i]  <= opDstLog;
          unitOf[i]  <= opUnit;
        end
      end
    end
  end

  // Resident function table with round-robin replacement
  logic [FUNC_W-1:0] residentFunc [NUM_CTX];
  logic [CTX_W-1:0]  rrPtr;

  always_comb begin
    ctxHit = 1'b0;
    for (int k = 0; k < NUM_CTX; k++)
      if (residentFunc[k] == opFunc) ctxHit = 1'b1;
  end

  assign funcDefined = opFunc < FUNC_W'(NUM_FUNCS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
      for (int k = 0; k < NUM_CTX; k++) residentFunc[k] <= FUNC_W'(k);
    end else if (strobes.ctxInstall) begin
      residentFunc[rrPtr] <= opFunc;
      rrPtr <= (rrPtr == CTX_W'(NUM_CTX - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
(
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       opValid,
  input  logic       cpuHitSrc,
  input  logic       cpuHitDst,
  input  logic       opDstHit,
  input  logic       opSrcHit,
  input  logic       tableFull,
  input  logic       unitBusy,
  input  logic       ctxHit,
  input  logic       funcDefined,
  input  logic       ctxAck,
  output logic       cpuStall,
  output logic       opStall,
  output logic       opGrant,
  output logic       ctxReq,
  output sbStrobes_t strobes
);
  logic opBlocked;

  always_comb begin
    cpuStall  = cpuValid && (cpuHitDst || (cpuWrite && cpuHitSrc));
    opBlocked = opDstHit || opSrcHit || tableFull || unitBusy || !ctxHit || !funcDefined;
    opStall   = opValid && opBlocked;
    opGrant   = opValid && !opBlocked;
    ctxReq    = opValid && funcDefined && !ctxHit;
    strobes.alloc      = opGrant;
    strobes.ctxInstall = ctxReq && ctxAck;
  end
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard
  import sb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LOG_W       = 4,
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_UNITS   = 8,
  parameter int UNIT_W      = $clog2(NUM_UNITS),
  parameter int FUNC_W      = 4,
  parameter int NUM_FUNCS   = 14,
  parameter int NUM_CTX     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpuValid,
  input  logic                 cpuWrite,
  input  logic [ADDR_W-1:0]    cpuAddr,
  output logic                 cpuStall,
  input  logic                 opValid,
  input  logic [FUNC_W-1:0]    opFunc,
  input  logic [UNIT_W-1:0]    opUnit,
  input  logic [ADDR_W-1:0]    opSrcBase,
  input  logic [LOG_W-1:0]     opSrcLog,
  input  logic [ADDR_W-1:0]    opDstBase,
  input  logic [LOG_W-1:0]     opDstLog,
  output logic                 opStall,
  output logic                 opGrant,
  input  logic [NUM_UNITS-1:0] donePulse,
  output logic                 ctxReq,
  output logic [FUNC_W-1:0]    ctxFunc,
  input  logic                 ctxAck
);
  sbStrobes_t strobes;
  logic cpuHitSrc, cpuHitDst, opDstHit, opSrcHit, tableFull, unitBusy, ctxHit, funcDefined;
  logic [NUM_ENTRIES-1:0] entryValid;

  sb_datapath #(
    .ADDR_W(ADDR_W), .LOG_W(LOG_W), .NUM_ENTRIES(NUM_ENTRIES), .NUM_UNITS(NUM_UNITS),
    .UNIT_W(UNIT_W), .FUNC_W(FUNC_W), .NUM_FUNCS(NUM_FUNCS), .NUM_CTX(NUM_CTX)
  ) uDatapath (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .opFunc(opFunc), .opUnit(opUnit),
    .opSrcBase(opSrcBase), .opSrcLog(opSrcLog), .opDstBase(opDstBase), .opDstLog(opDstLog),
    .donePulse(donePulse), .strobes(strobes), .cpuHitSrc(cpuHitSrc), .cpuHitDst(cpuHitDst),
    .opDstHit(opDstHit), .opSrcHit(opSrcHit), .tableFull(tableFull), .unitBusy(unitBusy),
    .ctxHit(ctxHit), .funcDefined(funcDefined), .entryValid(entryValid)
  );

  sb_control uControl (
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .opValid(opValid), .cpuHitSrc(cpuHitSrc),
    .cpuHitDst(cpuHitDst), .opDstHit(opDstHit), .opSrcHit(opSrcHit), .tableFull(tableFull),
    .unitBusy(unitBusy), .ctxHit(ctxHit), .funcDefined(funcDefined), .ctxAck(ctxAck),
    .cpuStall(cpuStall), .opStall(opStall), .opGrant(opGrant), .ctxReq(ctxReq),
    .strobes(strobes)
  );

  assign ctxFunc = opFunc;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_UNITS   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpuStall,
  input logic                   opValid,
  input logic                   opStall,
  input logic                   opGrant,
  input logic                   ctxReq,
  input logic [NUM_UNITS-1:0]   donePulse,
  input logic [NUM_ENTRIES-1:0] entryValid
);
  // R7: a full table never grants
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(entryValid) == NUM_ENTRIES) |-> !opGrant);

  // R7/R11: a grant with no completion adds exactly one entry
  a_r11_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (opGrant && donePulse == '0) |=> ($countones(entryValid) == $countones($past(entryValid)) + 1));

  // R9: without grant or completion the table holds still
  a_r9_table_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!opGrant && donePulse == '0) |=> $stable(entryValid));

  // R2: an empty table never stalls the processor
  a_r2_empty_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (entryValid == '0) |-> !cpuStall);

  // R10: an outstanding load request keeps the operation stalled
  a_r10_req_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ctxReq |-> (opValid && opStall));
endmodule

bind region_scoreboard sb_checker #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_UNITS(NUM_UNITS)) uChecker (
  .clk(clk), .rst_n(rst_n), .cpuStall(cpuStall), .opValid(opValid), .opStall(opStall),
  .opGrant(opGrant), .ctxReq(ctxReq), .donePulse(donePulse), .entryValid(entryValid)
);

// File: tb/tb_region_scoreboard.sv
`timescale 1ns/1ps
module tb_region_scoreboard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuValid = 0, cpuWrite = 0;
  logic [15:0] cpuAddr = '0;
  logic opValid = 0;
  logic [3:0] opFunc = '0;
  logic [2:0] opUnit = '0;
  logic [15:0] opSrcBase = '0, opDstBase = '0;
  logic [3:0] opSrcLog = '0, opDstLog = '0;
  logic [7:0] donePulse = '0;
  logic ctxAck = 0;
  logic cpuStall, opStall, opGrant, ctxReq;
  logic [3:0] ctxFunc;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  int mv[4], mu[4], ms[4], msl[4], md[4], mdl[4];
  int ctxTab[4];
  int rr;

  always #2.5 clk = ~clk;

  region_scoreboard dut (
    .clk(clk), .rst_n(rst_n), .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuStall(cpuStall), .opValid(opValid), .opFunc(opFunc), .opUnit(opUnit),
    .opSrcBase(opSrcBase), .opSrcLog(opSrcLog), .opDstBase(opDstBase), .opDstLog(opDstLog),
    .opStall(opStall), .opGrant(opGrant), .donePulse(donePulse), .ctxReq(ctxReq),
    .ctxFunc(ctxFunc), .ctxAck(ctxAck)
  );

  function automatic bit ov(int a, int la, int b, int lb);
    int sa = a - (a % (1 << la));
    int sb = b - (b % (1 << lb));
    int ea = sa + (1 << la) - 1;
    int eb = sb + (1 << lb) - 1;
    return (sa <= eb) && (sb <= ea);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare one cycle against the model, then advance the model
  task automatic tick(string tag);
    bit hitS = 0, hitD = 0, dstHit = 0, srcHit = 0, busy = 0, res = 0, defd, blk;
    int cnt = 0, slot = -1;
    bit expCpu, expReq, expGrant;
    #1;
    for (int i = 0; i < 4; i++) if (mv[i]) begin
      cnt++;
      if (ov(cpuAddr, 0, ms[i], msl[i])) hitS = 1;
      if (ov(cpuAddr, 0, md[i], mdl[i])) hitD = 1;
      if (ov(opDstBase, opDstLog, md[i], mdl[i]) || ov(opDstBase, opDstLog, ms[i], msl[i])) dstHit = 1;
      if (ov(opSrcBase, opSrcLog, md[i], mdl[i])) srcHit = 1;
      if (mu[i] == opUnit) busy = 1;
    end
    for (int k = 0; k < 4; k++) if (ctxTab[k] == opFunc) res = 1;
    defd = opFunc < 14;
    blk = dstHit || srcHit || busy || (cnt == 4) || !res || !defd;
    expCpu = cpuValid && (hitD || (cpuWrite && hitS));
    expGrant = opValid && !blk;
    expReq = opValid && defd && !res;
    chk(tag, "cpuStall", cpuStall, expCpu);
    chk(tag, "opStall", opStall, opValid && blk);
    chk(tag, "opGrant", opGrant, expGrant);
    chk(tag, "ctxReq", ctxReq, expReq);
    if (expReq) chk(tag, "ctxFunc", ctxFunc, opFunc);
    // advance model
    if (expGrant) for (int i = 3; i >= 0; i--) if (!mv[i]) slot = i;
    for (int i = 0; i < 4; i++) if (mv[i] && donePulse[mu[i]]) mv[i] = 0;
    if (slot >= 0) begin
      mv[slot] = 1; mu[slot] = opUnit; ms[slot] = opSrcBase; msl[slot] = opSrcLog;
      md[slot] = opDstBase; mdl[slot] = opDstLog;
    end
    if (expReq && ctxAck) begin ctxTab[rr] = opFunc; rr = (rr + 1) % 4; end
    @(negedge clk);
    donePulse = '0;
    ctxAck = 0;
  endtask

  task automatic setOp(int u, int f, int s, int sl, int d, int dl);
    opValid = 1; opUnit = 3'(u); opFunc = 4'(f);
    opSrcBase = 16'(s); opSrcLog = 4'(sl); opDstBase = 16'(d); opDstLog = 4'(dl);
  endtask

  task automatic noOp();
    opValid = 0;
  endtask

  task automatic cpu(bit v, bit w, int a);
    cpuValid = v; cpuWrite = w; cpuAddr = 16'(a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 0; ctxTab[i] = i; end
    rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cpu(1, 1, 'h1234);
    tick("R1");
    setOp(5, 3, 'h0100, 2, 'h0200, 2); opValid = 0;
    tick("R1");
    cpu(0, 0, 0);
    // R11 basic issue
    setOp(0, 1, 'h1000, 4, 'h2000, 4); tick("R11"); noOp();
    // R2 / R3 processor accesses
    cpu(1, 1, 'h1008); tick("R2");
    cpu(1, 0, 'h1008); tick("R3");
    cpu(1, 0, 'h2003); tick("R3");
    cpu(1, 1, 'h3000); tick("R2");
    cpu(0, 0, 0);
    // R5 source checks
    setOp(1, 2, 'h1000, 3, 'h4000, 2); tick("R5"); noOp();
    setOp(2, 3, 'h2008, 3, 'h6000, 2); tick("R5");
    // R4 destination checks
    setOp(2, 1, 'h5000, 2, 'h1004, 2); tick("R4");
    setOp(2, 1, 'h5000, 2, 'h4002, 1); tick("R4");
    // R6 masking by larger block, unaligned bases
    setOp(2, 1, 'h7000, 2, 'h2400, 13); tick("R6");
    setOp(2, 1, 'h7000, 2, 'h5003, 2); tick("R6"); noOp();
    cpu(1, 1, 'h5000); tick("R6");
    cpu(1, 1, 'h5004); tick("R6");
    cpu(0, 0, 0);
    // R8 busy unit
    setOp(0, 2, 'h9000, 2, 'hA000, 2); tick("R8");
    // R7 full table
    setOp(3, 1, 'hB000, 2, 'hC000, 2); tick("R7");
    setOp(4, 1, 'hD000, 2, 'hE000, 2); tick("R7"); tick("R7");
    // R9 completion in the same cycle as a blocked issue
    donePulse = 8'h01; tick("R9");
    tick("R9"); noOp();
    cpu(1, 1, 'h1008); tick("R9");
    cpu(1, 1, 'h1004); tick("R9");
    cpu(0, 0, 0);
    donePulse = 8'hFF; tick("R9"); tick("R9");
    // R10 context loading
    setOp(0, 9, 'h0100, 2, 'h0200, 2); tick("R10"); tick("R10"); tick("R10");
    ctxAck = 1; tick("R10");
    tick("R10"); noOp();
    donePulse = 8'hFF; tick("R10");
    setOp(1, 10, 'h0100, 2, 'h0200, 2); ctxAck = 1; tick("R10");
    tick("R10"); noOp();
    donePulse = 8'hFF; tick("R10");
    setOp(2, 0, 'h0100, 2, 'h0200, 2); tick("R10"); tick("R10");
    setOp(2, 2, 'h0100, 2, 'h0200, 2); tick("R10"); noOp();
    donePulse = 8'hFF; tick("R10");
    // R12 undefined functions
    setOp(3, 14, 'h0100, 2, 'h0200, 2); ctxAck = 1; tick("R12");
    setOp(3, 15, 'h0100, 2, 'h0200, 2); tick("R12"); noOp();
    tick("R12");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule